// File: doc/BRIEF.md
# Hierarchical Summary Interrupt Coalescer

The block turns per-device input notifications into interrupt requests, while letting a program that polls often avoid being interrupted at all. Sixteen devices each own a state-change flag. The flags are split into two groups, and each group has a group summary flag. One global summary flag covers everything. A device event lands in the indicators as a short ripple: the device flag first, then its group flag, then the global flag. Each level appears one clock after the level below it.

When the global flag goes from clear to set, the block records the current value of a free-running timestamp. On every following clock it measures the time since that stamp, using modulo-2^32 subtraction. An interrupt pulse is issued only when all of these hold: the facility is enabled, the measured time exceeds a programmable delay, at least one device flag is still set, and the global flag has not been polled clear. A program polls the global flag with a test-and-clear access. If it polls within the delay window, the interrupt is never raised. At most one pulse is issued for each activation of the global flag.

The facility is off after reset. It is turned on by an explicit enable command and then stays on until reset. The delay register accepts writes only once the facility is enabled.

Top module: `hsum_coalescer`

## Requirements
- R1: After reset all device, group and global flags are 0, `irq` is 0, the facility is disabled and the delay register holds 0.
- R2: A 1 on `dev_evt[d]` sets `dev_flags[d]` at the next clock edge. It sets `grp_flags[d/8]` one edge later, and `glob_flag` one edge after that.
- R3: When a set and a clear hit the same flag in the same cycle, the set wins. If `glob_tc` coincides with a global set, this starts a new activation.
- R4: A 1 in any bit of `dev_clr` or `grp_clr` clears only that flag. `glob_tc` clears `glob_flag` at the next edge, and `glob_flag` shows the tested value before that edge.
- R5: The value of `now` is captured at the edge where the global flag is set from clear, or where it is set again under R3.
- R6: `irq` is high for the one cycle after an edge where all of these hold: the facility is enabled, `glob_flag` is 1, `glob_tc` is 0, no pulse has been issued for this activation, `now` minus the stamp (mod 2^32) is greater than the delay, and some device flag is 1.
- R7: No pulse is issued if the global flag is polled clear before the delay is exceeded, or if no device flag is set.
- R8: Only one pulse is issued per activation. A later activation can issue a new pulse.
- R9: `en_cmd` enables the facility, and the facility stays enabled until reset. No pulse is issued while it is disabled. `dly_wr` loads `dly_data` only while the facility is enabled; while it is disabled the write has no effect.
- R10: The elapsed-time comparison works correctly when `now` wraps past 2^32-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system/image reset |
| en_cmd | input | 1 | Enable command pulse |
| dly_wr | input | 1 | Delay register write strobe |
| dly_data | input | 32 | Delay value in timestamp ticks |
| now | input | 32 | Free-running timestamp |
| dev_evt | input | 16 | Device set events from the adapter |
| dev_clr | input | 16 | Program clear write for device flags |
| grp_clr | input | 2 | Program clear write for group flags |
| glob_tc | input | 1 | Test-and-clear of the global flag |
| dev_flags | output | 16 | Device state-change flags |
| grp_flags | output | 2 | Group summary flags |
| glob_flag | output | 1 | Global summary flag |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench measures the exact cycle of the first pulse for several delays, including a run where the timestamp wraps.

- A design that compares with `>=` would pulse one cycle early. So would one that stamps the wrong edge.
- One that compares without modulo arithmetic would stay silent across the wrap.

Other scenarios target specific mistakes:

- Polling inside the window, and clearing every device flag before the deadline, must both give silence. A design that ignores the poll or the device check would interrupt.
- A delay written before enabling must have no effect. A design that accepts the write would shift the pulse timing.
- A same-cycle device set and clear exposes the wrong priority.
- Repeated activations expose a pulse that either repeats or never re-arms.

// File: rtl/hsum_coalescer.sv
module hsum_coalescer #(
  parameter int NDEV = 16,
  parameter int NGRP = 2,
  parameter int TW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_cmd,
  input  logic            dly_wr,
  input  logic [TW-1:0]   dly_data,
  input  logic [TW-1:0]   now,
  input  logic [NDEV-1:0] dev_evt,
  input  logic [NDEV-1:0] dev_clr,
  input  logic [NGRP-1:0] grp_clr,
  input  logic            glob_tc,
  output logic [NDEV-1:0] dev_flags,
  output logic [NGRP-1:0] grp_flags,
  output logic            glob_flag,
  output logic            irq
);
  localparam int GSZ = NDEV / NGRP;

  logic [NDEV-1:0] dev_q;
  logic [NGRP-1:0] grp_q, grp_pend_q, grp_hit;
  logic            glob_q, glob_pend_q;
  logic            en_q, fired_q, irq_q;
  logic [TW-1:0]   dly_q, stamp_q, elapsed;
  logic            rearm, fire;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_hit[g] = |dev_evt[g*GSZ +: GSZ];
  end

  assign elapsed = now - stamp_q;
  assign rearm   = glob_pend_q & (~glob_q | glob_tc);
  assign fire    = en_q & glob_q & ~glob_tc & ~fired_q & (elapsed > dly_q) & (|dev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q       <= '0;
      grp_q       <= '0;
      grp_pend_q  <= '0;
      glob_q      <= 1'b0;
      glob_pend_q <= 1'b0;
      en_q        <= 1'b0;
      fired_q     <= 1'b0;
      irq_q       <= 1'b0;
      dly_q       <= '0;
      stamp_q     <= '0;
    end else begin
      dev_q       <= (dev_q & ~dev_clr) | dev_evt;
      grp_pend_q  <= grp_hit;
      grp_q       <= (grp_q & ~grp_clr) | grp_pend_q;
      glob_pend_q <= |grp_pend_q;
      glob_q      <= (glob_q & ~glob_tc) | glob_pend_q;
      if (en_cmd) en_q <= 1'b1;
      if (dly_wr && en_q) dly_q <= dly_data;
      if (rearm) begin
        stamp_q <= now;
        fired_q <= 1'b0;
      end else if (fire) begin
        fired_q <= 1'b1;
      end
      irq_q <= fire;
    end
  end

  assign dev_flags = dev_q;
  assign grp_flags = grp_q;
  assign glob_flag = glob_q;
  assign irq       = irq_q;
endmodule

module hsum_coalescer_chk #(
  parameter int NDEV = 16,
  parameter int NGRP = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_q,
  input logic [NDEV-1:0] dev_flags,
  input logic [NGRP-1:0] grp_flags,
  input logic            glob_flag,
  input logic            irq
);
  localparam int GSZ = NDEV / NGRP;

  // R9
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);
  // R9
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> en_q);
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R6
  irq_glob_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> glob_flag);
  // R7
  irq_dev_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(|dev_flags));
  // R2
  glob_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glob_flag) |-> $past(|grp_flags));
  for (genvar g = 0; g < NGRP; g++) begin : g_ord
    // R2
    grp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_flags[g]) |-> $past(|dev_flags[g*GSZ +: GSZ]));
  end
endmodule

bind hsum_coalescer hsum_coalescer_chk #(.NDEV(NDEV), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .dev_flags(dev_flags),
  .grp_flags(grp_flags), .glob_flag(glob_flag), .irq(irq)
);

// File: tb/sim_hsum_coalescer.sv
module sim_hsum_coalescer;
  logic clk = 0, rst_n = 0;
  logic en_cmd = 0, dly_wr = 0, glob_tc = 0;
  logic [31:0] dly_data = 0, now = 0, ld_val = 0;
  logic ld = 0;
  logic [15:0] dev_evt = 0, dev_clr = 0;
  logic [1:0] grp_clr = 0;
  logic [15:0] dev_flags;
  logic [1:0] grp_flags;
  logic glob_flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) now <= ld ? ld_val : now + 1;

  hsum_coalescer u0 (.clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dly_wr(dly_wr),
    .dly_data(dly_data), .now(now), .dev_evt(dev_evt), .dev_clr(dev_clr),
    .grp_clr(grp_clr), .glob_tc(glob_tc), .dev_flags(dev_flags),
    .grp_flags(grp_flags), .glob_flag(glob_flag), .irq(irq));

  // behavioural reference
  bit m_dev[16];
  bit m_grp[2], m_pg[2];
  bit m_glob, m_pa, m_irq, m_fired, m_en;
  logic [31:0] m_dly, m_stamp;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_dev[i]) m_dev[i] = 0;
      foreach (m_grp[i]) begin m_grp[i] = 0; m_pg[i] = 0; end
      m_glob = 0; m_pa = 0; m_irq = 0; m_fired = 0; m_en = 0;
      m_dly = 0; m_stamp = 0;
    end else begin
      bit any_dev, set_g, n_pa;
      bit n_pg[2];
      any_dev = 0;
      foreach (m_dev[i]) if (m_dev[i]) any_dev = 1;
      m_irq = m_en && m_glob && !glob_tc && !m_fired && ((now - m_stamp) > m_dly) && any_dev;
      if (m_irq) m_fired = 1;
      set_g = m_pa;
      if (set_g && (!m_glob || glob_tc)) begin m_stamp = now; m_fired = 0; end
      m_glob = (m_glob && !glob_tc) || set_g;
      n_pa = 0;
      foreach (m_grp[g]) begin
        if (m_pg[g]) begin m_grp[g] = 1; n_pa = 1; end
        else if (grp_clr[g]) m_grp[g] = 0;
        n_pg[g] = 0;
      end
      for (int d = 0; d < 16; d++) begin
        if (dev_evt[d]) begin m_dev[d] = 1; n_pg[d/8] = 1; end
        else if (dev_clr[d]) m_dev[d] = 0;
      end
      m_pa = n_pa;
      m_pg = n_pg;
      if (dly_wr && m_en) m_dly = dly_data;
      if (en_cmd) m_en = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [15:0] ed;
    ed = 0;
    for (int d = 0; d < 16; d++) ed[d] = m_dev[d];
    chk(dev_flags == ed && grp_flags == {m_grp[1], m_grp[0]} && glob_flag == m_glob,
        "R2 model flags", {13'd0, glob_flag, grp_flags, dev_flags}, {13'd0, m_glob, m_grp[1], m_grp[0], ed});
    chk(irq == m_irq, "R6 model irq", irq, m_irq);
  end

  task automatic step(); @(negedge clk); endtask

  task automatic clr_all();
    dev_clr = '1; grp_clr = '1; glob_tc = 1; step();
    dev_clr = 0; grp_clr = 0; glob_tc = 0; step();
  endtask

  task automatic fire_run(input int bit_i, input int limit, output int first, output int pulses);
    first = 0; pulses = 0;
    dev_evt = 16'(1) << bit_i;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (i == 1) dev_evt = 0;
      if (irq) begin pulses++; if (first == 0) first = i; end
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    int first, pulses;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1
    chk(dev_flags == 0 && grp_flags == 0 && !glob_flag, "R1 flags after reset", {glob_flag, grp_flags, dev_flags}, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);

    // R9: delay write while disabled is ignored
    dly_wr = 1; dly_data = 5; step(); dly_wr = 0;

    // R2 ripple order, facility disabled
    dev_evt = 16'h0008; step(); dev_evt = 0;
    chk(dev_flags == 16'h0008 && grp_flags == 0 && !glob_flag, "R2 device first", {glob_flag, grp_flags, dev_flags}, 32'h8);
    step();
    chk(grp_flags == 2'b01 && !glob_flag, "R2 group second", {glob_flag, grp_flags}, 1);
    step();
    chk(glob_flag == 1, "R2 global third", glob_flag, 1);
    pulses = 0;
    repeat (20) begin step(); if (irq) pulses++; end
    chk(pulses == 0, "R9 no irq while disabled", pulses, 0);

    // R4 selective clears
    dev_evt = 16'h1001; step(); dev_evt = 0; repeat (3) step();
    dev_clr = 16'h0001; grp_clr = 2'b10; step(); dev_clr = 0; grp_clr = 0;
    chk(dev_flags == 16'h1008, "R4 selective dev clear", dev_flags, 32'h1008);
    chk(grp_flags == 2'b01, "R4 selective grp clear", grp_flags, 1);
    glob_tc = 1; step(); glob_tc = 0;
    chk(glob_flag == 0, "R4 test-and-clear", glob_flag, 0);

    // R3 set wins
    dev_evt = 16'h0080; dev_clr = 16'h0080; step(); dev_evt = 0; dev_clr = 0;
    chk(dev_flags[7] == 1, "R3 set wins over clear", dev_flags[7], 1);
    repeat (3) step();
    clr_all();

    // enable; delay still 0 => first pulse at cycle 4
    en_cmd = 1; step(); en_cmd = 0;
    fire_run(2, 30, first, pulses);
    chk(first == 4, "R9 ignored delay write, R5 stamp, R6 timing", first, 4);
    chk(pulses == 1, "R8 single pulse", pulses, 1);
    clr_all();

    dly_wr = 1; dly_data = 10; step(); dly_wr = 0;
    fire_run(12, 40, first, pulses);
    chk(first == 14, "R6 delay 10 timing", first, 14);
    chk(pulses == 1, "R8 one pulse per activation", pulses, 1);
    clr_all();

    dly_wr = 1; dly_data = 3; step(); dly_wr = 0;
    fire_run(9, 30, first, pulses);
    chk(first == 7 && pulses == 1, "R8 rearm after new activation", first, 7);
    clr_all();

    // R7 polling suppresses
    dly_wr = 1; dly_data = 10; step(); dly_wr = 0;
    dev_evt = 16'h0001; step(); dev_evt = 0;
    pulses = 0;
    for (int i = 2; i <= 40; i++) begin
      glob_tc = (i % 4 == 0); step();
      if (irq) pulses++;
    end
    glob_tc = 0;
    chk(pulses == 0, "R7 polling suppresses", pulses, 0);
    clr_all();

    // R7 no device flag left
    dev_evt = 16'h0020; step(); dev_evt = 0;
    dev_clr = 16'h0020; step(); dev_clr = 0;
    pulses = 0;
    repeat (30) begin step(); if (irq) pulses++; end
    chk(glob_flag == 1, "R7 global stays set", glob_flag, 1);
    chk(pulses == 0, "R7 no device flag no irq", pulses, 0);
    clr_all();

    // R10 wraparound
    ld = 1; ld_val = 32'hFFFF_FFF8; step(); ld = 0;
    fire_run(15, 40, first, pulses);
    chk(first == 14 && pulses == 1, "R10 wraparound timing", first, 14);
    clr_all();

    repeat (3) step();
    finish_up();
  end
endmodule